// File: doc/BRIEF.md
# DS3 M-Frame Generator with Payload-Carried C Slots

This block produces a serial DS3 M-frame in the M23 layout. The positions that would normally hold stuffing-control C bits are given to payload, so the only overhead the generator inserts is the X, P, M and F bits. Payload arrives one bit at a time over a ready/valid handshake. A clock-enable input paces the line, and each enabled cycle presents exactly one line bit.

An M-frame is seven subframes. Each subframe is eight blocks, and each block is one leading slot followed by a run of payload bits (84 by default, so 680 bits per subframe). In block 0 of each subframe the leading slot carries the subframe's label bit. In the odd blocks it carries an F bit. In the even blocks from 2 upward it carries payload.

A frame-start marker and a subframe-start marker are active during the enabled cycle in which the first bit of the frame or subframe is on the line. The two P bits of each frame carry the parity of the payload that the previous frame sent. Frame boundary detection in the receiver, line coding and the payload's own structure are handled elsewhere.

Top module: `ds3_mframe_gen`

## Requirements
- R1: The frame is SUBS subframes × BLOCKS blocks × (BLOCK_BITS+1) bits long. `sub_start` is active in the enabled cycle where block 0, bit 0 of a subframe is on the line. `frame_start` is active only where this happens in subframe 0.
- R2: The leading bit of block 0 in subframes 0 through 6 is, in order: far_alarm, far_alarm, P, P, 0, 1, 0.
- R3: The leading bits of blocks 1, 3, 5 and 7 are the F bits, with values 1, 0, 0 and 1 in that order.
- R4: The leading bits of blocks 2, 4 and 6 are payload slots: `pl_ready` is high and the line carries payload there.
- R5: `pl_ready` is low in every overhead slot (block-0 leading bit and F bits). It is high in every enabled payload slot.
- R6: When `pl_valid` is high in a payload slot, `line_bit` equals `pl_data` in that cycle and the bit is consumed. Payload bits therefore go out in the order they were offered.
- R7: A payload slot with `pl_valid` low sends 1 on the line.
- R8: Both P bits of a frame equal the XOR of every payload-slot line bit of the previous frame, fill bits included. In the first frame after reset, both P bits are 0.
- R9: Synchronous reset returns the generator to subframe 0, block 0, bit 0. In the first enabled cycle after reset, `frame_start` is high. While `ce` stays low after reset, `pl_ready` and the markers stay low.
- R10: In a cycle with `ce` low, the frame position holds, and `pl_ready`, `frame_start` and `sub_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Line bit enable; one line bit per enabled cycle |
| far_alarm | input | 1 | Value sent in both X bits; tie high when idle |
| pl_data | input | 1 | Payload bit offered |
| pl_valid | input | 1 | Payload bit offered is valid |
| pl_ready | output | 1 | Payload slot on the line this cycle; a bit is consumed when valid is also high |
| line_bit | output | 1 | Serial line bit, meaningful when `ce` is high |
| frame_start | output | 1 | First bit of the M-frame is on the line |
| sub_start | output | 1 | First bit of a subframe is on the line |

## Verification
The bench builds the generator with BLOCK_BITS set to 4 and the subframe and block counts at their defaults. This keeps a whole M-frame at 280 line bits, so several complete frames fit in a short run. With frames that short, the run covers:
- the parity carried from one frame into the next;
- the alarm value changing between frames;
- a reset part-way through a frame.

Along the way, gapped `ce` patterns and payload underflow are exercised in every slot type.

// File: rtl/ds3_mf_pkg.sv
package ds3_mf_pkg;
   typedef enum logic [1:0] {
      SLOT_PAY  = 2'd0,
      SLOT_LEAD = 2'd1,
      SLOT_FBIT = 2'd2
   } slot_e;
endpackage

// File: rtl/ds3_pos_cnt.sv
module ds3_pos_cnt #(
   parameter int BLOCK_BITS = 84,
   parameter int BLOCKS     = 8,
   parameter int SUBS       = 7,
   localparam int SW  = $clog2(SUBS),
   localparam int BKW = $clog2(BLOCKS),
   localparam int BW  = $clog2(BLOCK_BITS + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ce,
   output logic [SW-1:0]  sub_idx,
   output logic [BKW-1:0] blk_idx,
   output logic [BW-1:0]  bit_idx,
   output logic           frame_last
);
   localparam logic [BW-1:0]  LAST_BIT = BW'(BLOCK_BITS);
   localparam logic [BKW-1:0] LAST_BLK = BKW'(BLOCKS - 1);
   localparam logic [SW-1:0]  LAST_SUB = SW'(SUBS - 1);

   logic bit_wrap, blk_wrap;
   assign bit_wrap   = (bit_idx == LAST_BIT);
   assign blk_wrap   = (blk_idx == LAST_BLK);
   assign frame_last = bit_wrap && blk_wrap && (sub_idx == LAST_SUB);

   always_ff @(posedge clk) begin
      if (rst) begin
         sub_idx <= '0;
         blk_idx <= '0;
         bit_idx <= '0;
      end else if (ce) begin
         if (bit_wrap) begin
            bit_idx <= '0;
            if (blk_wrap) begin
               blk_idx <= '0;
               sub_idx <= (sub_idx == LAST_SUB) ? '0 : sub_idx + 1'b1;
            end else begin
               blk_idx <= blk_idx + 1'b1;
            end
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ds3_oh_sel.sv
module ds3_oh_sel
   import ds3_mf_pkg::*;
#(
   parameter int              BLOCKS = 8,
   parameter int              SUBS   = 7,
   parameter logic [BLOCKS/2-1:0] F_SEQ = 4'b1001,
   parameter logic [2:0]      M_SEQ  = 3'b010,
   localparam int SW  = $clog2(SUBS),
   localparam int BKW = $clog2(BLOCKS)
) (
   input  logic [SW-1:0]  sub_idx,
   input  logic [BKW-1:0] blk_idx,
   input  logic           blk_head,
   input  logic           far_alarm,
   input  logic           par_prev,
   output slot_e          slot,
   output logic           oh_bit
);
   logic [SUBS-1:0] lead_vec;

   for (genvar g = 0; g < SUBS; g++) begin : g_lead
      if (g < 2) begin : g_x
         assign lead_vec[g] = far_alarm;
      end else if (g < 4) begin : g_p
         assign lead_vec[g] = par_prev;
      end else begin : g_m
         assign lead_vec[g] = M_SEQ[g-4];
      end
   end

   always_comb begin
      slot   = SLOT_PAY;
      oh_bit = 1'b0;
      if (blk_head) begin
         if (blk_idx == '0) begin
            slot   = SLOT_LEAD;
            oh_bit = lead_vec[sub_idx];
         end else if (blk_idx[0]) begin
            slot   = SLOT_FBIT;
            oh_bit = F_SEQ[blk_idx[BKW-1:1]];
         end
      end
   end
endmodule

// File: rtl/ds3_par_acc.sv
module ds3_par_acc (
   input  logic clk,
   input  logic rst,
   input  logic pay_tick,
   input  logic pay_bit,
   input  logic frame_end,
   output logic par_prev
);
   logic acc, acc_nxt;
   assign acc_nxt = acc ^ (pay_tick & pay_bit);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc      <= 1'b0;
         par_prev <= 1'b0;
      end else if (frame_end) begin
         acc      <= 1'b0;
         par_prev <= acc_nxt;
      end else begin
         acc      <= acc_nxt;
      end
   end
endmodule

// File: rtl/ds3_mframe_gen.sv
module ds3_mframe_gen
   import ds3_mf_pkg::*;
#(
   parameter int   BLOCK_BITS     = 84,
   parameter int   BLOCKS         = 8,
   parameter int   SUBS           = 7,
   parameter logic UNDERFLOW_FILL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic far_alarm,
   input  logic pl_data,
   input  logic pl_valid,
   output logic pl_ready,
   output logic line_bit,
   output logic frame_start,
   output logic sub_start
);
   localparam int SW  = $clog2(SUBS);
   localparam int BKW = $clog2(BLOCKS);
   localparam int BW  = $clog2(BLOCK_BITS + 1);

   if (SUBS != 7) begin : g_bad_subs
      $error("SUBS must be 7: the lead-bit labels cover exactly seven subframes");
   end
   if (BLOCKS < 2 || (BLOCKS % 2) != 0) begin : g_bad_blocks
      $error("BLOCKS must be even and at least 2");
   end
   if (BLOCK_BITS < 1) begin : g_bad_bits
      $error("BLOCK_BITS must be at least 1");
   end

   logic [SW-1:0]  sub_idx;
   logic [BKW-1:0] blk_idx;
   logic [BW-1:0]  bit_idx;
   logic           frame_last, blk_head, oh_bit, par_prev, is_pay;
   slot_e          slot;

   ds3_pos_cnt #(.BLOCK_BITS(BLOCK_BITS), .BLOCKS(BLOCKS), .SUBS(SUBS)) u_pos (
      .clk(clk), .rst(rst), .ce(ce),
      .sub_idx(sub_idx), .blk_idx(blk_idx), .bit_idx(bit_idx),
      .frame_last(frame_last)
   );

   assign blk_head = (bit_idx == '0);

   ds3_oh_sel #(.BLOCKS(BLOCKS), .SUBS(SUBS)) u_oh (
      .sub_idx(sub_idx), .blk_idx(blk_idx), .blk_head(blk_head),
      .far_alarm(far_alarm), .par_prev(par_prev),
      .slot(slot), .oh_bit(oh_bit)
   );

   assign is_pay      = (slot == SLOT_PAY);
   assign pl_ready    = ce && is_pay;
   assign line_bit    = is_pay ? (pl_valid ? pl_data : UNDERFLOW_FILL) : oh_bit;
   assign sub_start   = ce && blk_head && (blk_idx == '0);
   assign frame_start = sub_start && (sub_idx == '0);

   ds3_par_acc u_par (
      .clk(clk), .rst(rst),
      .pay_tick(pl_ready), .pay_bit(line_bit),
      .frame_end(ce && frame_last),
      .par_prev(par_prev)
   );
endmodule

// File: rtl/ds3_mframe_chk.sv
module ds3_mframe_chk #(
   parameter int BLOCK_BITS = 84,
   parameter int BLOCKS     = 8,
   parameter int SUBS       = 7,
   parameter int SW  = 3,
   parameter int BKW = 3,
   parameter int BW  = 7
) (
   input logic           clk,
   input logic           rst,
   input logic           ce,
   input logic           pl_valid,
   input logic           pl_ready,
   input logic           line_bit,
   input logic           frame_start,
   input logic           sub_start,
   input logic [SW-1:0]  sub_idx,
   input logic [BKW-1:0] blk_idx,
   input logic [BW-1:0]  bit_idx
);
   // R9
   reset_start_chk: assert property (@(posedge clk) rst |=> (!ce || frame_start));
   // R5
   lead_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
      sub_start |-> !pl_ready);
   // R10
   hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(sub_idx) && $stable(blk_idx) && $stable(bit_idx)));
   // R7
   underflow_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (pl_ready && !pl_valid) |-> line_bit);
   // R1
   pos_range_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(bit_idx) <= BLOCK_BITS) && (int'(blk_idx) < BLOCKS) && (int'(sub_idx) < SUBS));
   // R1
   frame_in_sub_chk: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> sub_start);
endmodule

bind ds3_mframe_gen ds3_mframe_chk #(
   .BLOCK_BITS(BLOCK_BITS), .BLOCKS(BLOCKS), .SUBS(SUBS),
   .SW(SW), .BKW(BKW), .BW(BW)
) u_chk (
   .clk(clk), .rst(rst), .ce(ce), .pl_valid(pl_valid), .pl_ready(pl_ready),
   .line_bit(line_bit), .frame_start(frame_start), .sub_start(sub_start),
   .sub_idx(sub_idx), .blk_idx(blk_idx), .bit_idx(bit_idx)
);

// File: tb/sim_ds3_mframe_gen.sv
module sim_ds3_mframe_gen;
   localparam int CLK_PERIOD = 10;
   localparam int BB   = 4;
   localparam int NBLK = 8;
   localparam int NSUB = 7;
   localparam int FRAME_LEN = NSUB * NBLK * (BB + 1);

   typedef struct {
      logic  line, rdy, fs, ss;
      logic  chk_line;
      string req_line;
      string req_mark;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1, ce = 1'b0, far_alarm = 1'b1, pl_data = 1'b0, pl_valid = 1'b0;
   logic pl_ready, line_bit, frame_start, sub_start;

   int checks = 0, fails = 0;
   exp_t sbq[$];
   bit   drive_done = 1'b0;

   int m_sub = 0, m_blk = 0, m_bit = 0;
   bit m_acc = 1'b0, m_prev = 1'b0, m_fresh = 1'b1;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   ds3_mframe_gen #(.BLOCK_BITS(BB), .BLOCKS(NBLK), .SUBS(NSUB)) u0 (
      .clk(clk), .rst(rst), .ce(ce), .far_alarm(far_alarm),
      .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
      .line_bit(line_bit), .frame_start(frame_start), .sub_start(sub_start)
   );

   task automatic check(input string req, input string what, input logic act, input logic expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, expv, $time);
      end
   endtask

   task automatic model_reset();
      m_sub = 0; m_blk = 0; m_bit = 0;
      m_acc = 1'b0; m_prev = 1'b0; m_fresh = 1'b1;
   endtask

   // driver: sets inputs, pushes expected result, advances its own frame model
   task automatic step(input bit c, input bit v, input bit fa);
      exp_t e;
      bit lead, pay;
      @(negedge clk);
      ce = c; pl_valid = v; pl_data = lfsr[0]; far_alarm = fa;
      lead = (m_bit == 0);
      pay  = 1'b0;
      e.chk_line = c;
      e.req_mark = m_fresh ? "R9" : (c ? "R1" : "R10");
      if (lead && m_blk == 0) begin
         case (m_sub)
            0, 1: begin e.line = fa;     e.req_line = "R2"; end
            2, 3: begin e.line = m_prev; e.req_line = "R8"; end
            5:    begin e.line = 1'b1;   e.req_line = "R2"; end
            default: begin e.line = 1'b0; e.req_line = "R2"; end
         endcase
      end else if (lead && (m_blk % 2) == 1) begin
         e.line = (m_blk == 1 || m_blk == 7);  // F1..F4 = 1,0,0,1 (R3)
         e.req_line = "R3";
      end else begin
         pay = 1'b1;
         e.line = v ? lfsr[0] : 1'b1;
         e.req_line = lead ? "R4" : (v ? "R6" : "R7");
      end
      e.rdy = c && pay;
      e.fs  = c && lead && m_blk == 0 && m_sub == 0;
      e.ss  = c && lead && m_blk == 0;
      sbq.push_back(e);
      if (c) begin
         m_fresh = 1'b0;
         if (pay) begin
            m_acc = m_acc ^ e.line;
            if (v) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         end
         if (m_bit == BB) begin
            m_bit = 0;
            if (m_blk == NBLK - 1) begin
               m_blk = 0;
               if (m_sub == NSUB - 1) begin
                  m_sub = 0;
                  m_prev = m_acc;  // parity of the frame just finished (R8)
                  m_acc = 1'b0;
               end else m_sub++;
            end else m_blk++;
         end else m_bit++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ce = 1'b0; pl_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   // monitor: pops the expected item and compares away from the clock edge
   always @(negedge clk) begin
      #2;
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         if (e.chk_line) check(e.req_line, "line_bit", line_bit, e.line);
         check(e.rdy ? "R5" : (e.chk_line ? "R5" : "R10"), "pl_ready", pl_ready, e.rdy);
         check(e.req_mark, "frame_start", frame_start, e.fs);
         check(e.req_mark, "sub_start", sub_start, e.ss);
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9: reset state with ce held low
      step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      // one full frame, continuous, all valid, alarm idle high (first-frame P = 0)
      for (int i = 0; i < FRAME_LEN; i++) step(1'b1, 1'b1, 1'b1);
      // two frames with gapped ce, underflow and alarm asserted low
      for (int i = 0; i < 3 * FRAME_LEN; i++)
         step((i % 5) != 3, (i % 7) != 0, (i < 2 * FRAME_LEN) ? 1'b0 : 1'b1);
      // reset part-way through a frame
      for (int i = 0; i < 97; i++) step(1'b1, (i % 3) != 0, 1'b1);
      do_reset();
      step(1'b0, 1'b1, 1'b1);
      // two frames after reset, valid sparse, parity restarts from zero
      for (int i = 0; i < 2 * FRAME_LEN + 5; i++) step(1'b1, (i % 4) != 1, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      drive_done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!drive_done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!drive_done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule